// File: doc/BRIEF.md
# Four-Channel Half-Step Base Tick Divider

This block turns one fast peripheral clock into four slower base ticks that pace serial-bus timing. Each tick is a single-cycle enable pulse in the input clock domain, not a real clock. A 32-bit configuration word holds one 8-bit code per channel. A channel with code `c` pulses on average once every `(c+2)/2` input cycles, so an odd code yields a half-integer ratio. The channel makes that ratio by alternating short and long intervals.

A 4-bit selector chooses one tick for a downstream timing generator. Value 0 gives every input cycle. Values 1 to 4 give channels 1 to 4. Values from 5 up take channel 4 and thin it further by a power of two. A write port with an enable and a data word replaces the whole configuration word. The write also restarts every channel in step, so no stray pulse appears.

Top module: `hs_basediv`

## Requirements
- R1: After a synchronous active-high reset, the configuration word is 0xC6411208. Channel k (k=1..4) takes its code from bits [8k-1:8k-8], so the ticks have average periods of 5, 10, 33.5 and 100 input cycles.
- R2: Let M = code+2 and let n count the cycles since the channel last restarted. The channel pulses in cycle n exactly when floor(2(n+1)/M) differs from floor(2n/M). For an even code, this gives a fixed interval of code/2+1 cycles.
- R3: For an odd code, the pulse intervals alternate between floor(M/2) and ceil(M/2) cycles, following the rule in R2.
- R4: A code of 0 makes that channel pulse in every cycle.
- R5: A write with `cfg_we` high loads `cfg_wdata` at the clock edge and restarts all four channels (n=0 in the following cycle). In the cycle after the write, a channel pulses only if its new code is 0.
- R6: With `tick_sel` = 0, `sel_tick` is high in every cycle.
- R7: With `tick_sel` = 1..4, `sel_tick` equals `base_tick[tick_sel-1]` in the same cycle.
- R8: With `tick_sel` = s in 5..15, `sel_tick` pulses on the channel-4 pulses whose count since the last restart is a multiple of 2^(s-4). This count includes the current pulse, so the 2^(s-4)-th pulse, the 2*2^(s-4)-th pulse and so on. A change of `tick_sel` takes effect in the same cycle.
- R9: A reset asserted during operation restores the reset word and restarts all channels and the channel-4 pulse count, as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | New configuration word, four 8-bit codes |
| tick_sel | input | 4 | Tick source select |
| base_tick | output | 4 | Base tick enables, bit k-1 for channel k |
| sel_tick | output | 1 | Selected tick for the downstream timing generator |

## Verification
A configuration write can land in the same cycle in which a channel's phase wraps and pulses. The restart must then win over the wrap. The bench provokes this by writing back-to-back and at random points, and by using codes of 0 and 1, which wrap almost every cycle. It judges each cycle against a per-channel cycle counter that returns to zero on every write. The channel-4 pulse count behind the thinned selections can also be cleared by a write in the same cycle it would advance. The expected selected tick is derived from a bench-side pulse count that obeys the same reset rule.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;

    parameter int unsigned CODE_W = 8;
    parameter int unsigned NUM_CH = 4;
    parameter int unsigned SEL_W  = 4;

    localparam int unsigned ACC_W = CODE_W + 2;
    localparam int unsigned CFG_W = NUM_CH * CODE_W;
    localparam int unsigned PRE_W = (1 << SEL_W) - 1 - NUM_CH;
    localparam int unsigned IDX_W = $clog2(NUM_CH + 1);

    localparam logic [CFG_W-1:0] CFG_RESET_DEF = 32'hC641_1208;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [PRE_W-1:0]  pre_t;

    typedef struct packed {
        logic             load;
        logic [CFG_W-1:0] data;
    } cfg_wr_t;

    // Phase modulus of a channel: the code plus two half-steps.
    function automatic acc_t modulus(input code_t c);
        return acc_t'(c) + acc_t'(2);
    endfunction

    // Low (s - NUM_CH) bits set; zero for direct selections.
    function automatic pre_t pre_mask(input sel_t s);
        pre_t m;
        m = '0;
        for (int k = 0; k < int'(PRE_W); k++) begin
            if (k < int'(s) - int'(NUM_CH)) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hs_cfg_reg.sv
module hs_cfg_reg
    import hsdiv_pkg::*;
#(
    parameter logic [CFG_W-1:0] RST_VAL = CFG_RESET_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_wr_t          wr,
    output logic [CFG_W-1:0] cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= RST_VAL;
        end else if (wr.load) begin
            cfg_q <= wr.data;
        end
    end

endmodule

// File: rtl/hs_div_chan.sv
module hs_div_chan
    import hsdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  code_t code,
    output logic  tick
);

    // Phase advances by two half-steps per cycle and wraps modulo code+2.
    acc_t phase_q;
    acc_t phase_d;
    acc_t modv;
    acc_t sum;

    always_comb begin
        modv = modulus(code);
        sum  = phase_q + acc_t'(2);
        tick = (sum >= modv);
        if (clear) begin
            phase_d = '0;
        end else if (tick) begin
            phase_d = sum - modv;
        end else begin
            phase_d = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/hs_tick_mux.sv
module hs_tick_mux
    import hsdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [NUM_CH-1:0] base_tick,
    input  sel_t              sel,
    output logic              sel_tick
);

    pre_t              pre_q;
    pre_t              mask;
    logic [NUM_CH:0]   pick;
    logic              slow_hit;

    // Counts pulses of the last channel since the last restart.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_q <= '0;
        end else if (base_tick[NUM_CH-1]) begin
            pre_q <= pre_q + pre_t'(1);
        end
    end

    always_comb begin
        pick     = {base_tick, 1'b1};
        mask     = pre_mask(sel);
        slow_hit = base_tick[NUM_CH-1] && ((pre_q & mask) == mask);
        if (int'(sel) <= int'(NUM_CH)) begin
            sel_tick = pick[sel[IDX_W-1:0]];
        end else begin
            sel_tick = slow_hit;
        end
    end

endmodule

// File: rtl/hs_basediv.sv
module hs_basediv
    import hsdiv_pkg::*;
#(
    parameter logic [CFG_W-1:0] RST_VAL = CFG_RESET_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [SEL_W-1:0]  tick_sel,
    output logic [NUM_CH-1:0] base_tick,
    output logic              sel_tick
);

    cfg_wr_t          wr;
    logic [CFG_W-1:0] cfg_q;

    assign wr.load = cfg_we;
    assign wr.data = cfg_wdata;

    hs_cfg_reg #(
        .RST_VAL (RST_VAL)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .cfg_q (cfg_q)
    );

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_chan
        hs_div_chan u_chan (
            .clk   (clk),
            .rst   (rst),
            .clear (cfg_we),
            .code  (cfg_q[g*CODE_W +: CODE_W]),
            .tick  (base_tick[g])
        );
    end

    hs_tick_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .clear     (cfg_we),
        .base_tick (base_tick),
        .sel       (tick_sel),
        .sel_tick  (sel_tick)
    );

endmodule

// File: rtl/hsdiv_chk.sv
module hsdiv_chk
    import hsdiv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [SEL_W-1:0]  tick_sel,
    input logic [NUM_CH-1:0] base_tick,
    input logic              sel_tick,
    input logic [CFG_W-1:0]  cfg_q
);

    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
        AST_ZERO_CODE_SOLID: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[i*CODE_W +: CODE_W] == '0) |-> base_tick[i]); // R4

        AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
            cfg_we |=> (base_tick[i] == ($past(cfg_wdata[i*CODE_W +: CODE_W]) == '0))); // R5

        AST_PULSE_GAP: assert property (@(posedge clk) disable iff (rst)
            ((cfg_q[i*CODE_W +: CODE_W] >= CODE_W'(2)) && base_tick[i] && !cfg_we)
            |=> !base_tick[i]); // R2

        AST_SEL_DIRECT: assert property (@(posedge clk) disable iff (rst)
            (tick_sel == SEL_W'(i + 1)) |-> (sel_tick == base_tick[i])); // R7
    end

    AST_SEL_RAW: assert property (@(posedge clk) disable iff (rst)
        (tick_sel == '0) |-> sel_tick); // R6

    AST_SEL_SLOW: assert property (@(posedge clk) disable iff (rst)
        ((int'(tick_sel) > int'(NUM_CH)) && sel_tick) |-> base_tick[NUM_CH-1]); // R8

endmodule

bind hs_basediv hsdiv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .tick_sel  (tick_sel),
    .base_tick (base_tick),
    .sel_tick  (sel_tick),
    .cfg_q     (cfg_q)
);

// File: tb/hs_basediv_tb.sv
`timescale 1ns/1ps
module hs_basediv_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  tick_sel = '0;
    logic [3:0]  base_tick;
    logic        sel_tick;

    always #2.5 clk = ~clk;

    hs_basediv u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tick_sel  (tick_sel),
        .base_tick (base_tick),
        .sel_tick  (sel_tick)
    );

    int unsigned vec = 0;
    int unsigned bad = 0;
    bit          done = 1'b0;
    bit          seen_reset = 1'b0;

    // Bench model: configuration, cycles since restart, channel-4 pulse count.
    logic [31:0] m_cfg = '0;
    int          m_n[4];
    int          m_c4 = 0;
    int          m_src = 0; // 0 first reset, 1 later reset, 2 write

    function automatic bit exp_pulse(input int n, input int code);
        int m;
        m = code + 2;
        return ((2 * (n + 1)) / m) != ((2 * n) / m);
    endfunction

    function automatic int code_of(input int ch);
        return int'(m_cfg[ch*8 +: 8]);
    endfunction

    function automatic bit exp_sel(input int s);
        bit b4;
        b4 = exp_pulse(m_n[3], code_of(3));
        if (s == 0) return 1'b1;
        if (s <= 4) return exp_pulse(m_n[s-1], code_of(s-1));
        return b4 && (((m_c4 + 1) % (1 << (s - 4))) == 0);
    endfunction

    task automatic check();
        for (int i = 0; i < 4; i++) begin
            bit    e;
            string tag;
            e = exp_pulse(m_n[i], code_of(i));
            if (code_of(i) == 0)        tag = "R4";
            else if (m_src == 0)        tag = "R1";
            else if (m_src == 1)        tag = "R9";
            else if (m_n[i] == 0)       tag = "R5";
            else if (code_of(i) % 2)    tag = "R3";
            else                        tag = "R2";
            vec++;
            if (base_tick[i] !== e) begin
                bad++;
                $display("FAIL %s ch%0d n=%0d code=%0d: base_tick got %0b expected %0b",
                         tag, i + 1, m_n[i], code_of(i), base_tick[i], e);
            end
        end
        begin
            bit    e;
            string tag;
            e = exp_sel(int'(tick_sel));
            if (tick_sel == 0)      tag = "R6";
            else if (tick_sel <= 4) tag = "R7";
            else                    tag = "R8";
            vec++;
            if (sel_tick !== e) begin
                bad++;
                $display("FAIL %s sel=%0d c4=%0d: sel_tick got %0b expected %0b",
                         tag, tick_sel, m_c4, sel_tick, e);
            end
        end
    endtask

    // Advance the model across the coming clock edge using the driven inputs.
    task automatic model_edge();
        bit b4;
        b4 = exp_pulse(m_n[3], code_of(3));
        if (rst) begin
            m_cfg = 32'hC641_1208;
            foreach (m_n[k]) m_n[k] = 0;
            m_c4  = 0;
            m_src = seen_reset ? 1 : 0;
        end else if (cfg_we) begin
            m_cfg = cfg_wdata;
            foreach (m_n[k]) m_n[k] = 0;
            m_c4  = 0;
            m_src = 2;
        end else begin
            foreach (m_n[k]) m_n[k] = m_n[k] + 1;
            if (b4) m_c4 = m_c4 + 1;
        end
    endtask

    task automatic cycle();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check();
    endtask

    task automatic idle(input int k);
        for (int j = 0; j < k; j++) cycle();
    endtask

    task automatic write_cfg(input logic [31:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        cycle();
        cfg_we    = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cycle();
        cycle();
        rst = 1'b0;
        seen_reset = 1'b1;
    endtask

    task automatic rand_idle(input int k);
        for (int j = 0; j < k; j++) begin
            if ($urandom_range(0, 15) == 0) tick_sel = 4'($urandom_range(0, 15));
            cycle();
        end
    endtask

    function automatic logic [7:0] rand_code();
        if ($urandom_range(0, 1) == 0) return 8'($urandom_range(0, 9));
        return 8'($urandom_range(0, 255));
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        do_reset();

        // R1: reset word, observed on every selection path (R6, R7)
        for (int s = 0; s <= 4; s++) begin
            tick_sel = 4'(s);
            idle(220);
        end

        // R4: all codes zero
        write_cfg(32'h0000_0000);
        idle(20);

        // R3: odd codes, including the smallest
        write_cfg(32'h0103_0507);
        for (int s = 1; s <= 4; s++) begin
            tick_sel = 4'(s);
            idle(60);
        end

        // R8: channel 4 at full rate, then odd, thinned by every power of two
        write_cfg(32'h0011_FF02);
        for (int s = 5; s <= 12; s++) begin
            tick_sel = 4'(s);
            idle(300);
        end
        write_cfg(32'h0311_FE04);
        for (int s = 5; s <= 8; s++) begin
            tick_sel = 4'(s);
            idle(150);
        end

        // R5: back-to-back writes and a write right after restart
        tick_sel = 4'd4;
        write_cfg(32'h0102_0304);
        write_cfg(32'h0000_0001);
        write_cfg(32'h0501_0200);
        idle(3);
        write_cfg(32'h0201_0302);
        idle(40);

        // Random mix of configurations, holds, selections and resets
        for (int it = 0; it < 60; it++) begin
            if (it % 17 == 5) begin
                do_reset(); // R9
                rand_idle(250);
            end
            write_cfg({rand_code(), rand_code(), rand_code(), rand_code()});
            rand_idle(int'($urandom_range(1, 400)));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog (all requirements): got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule